// File: doc/BRIEF.md
# Programmable Memory State Checker

The block is a table-driven finite-state engine for memory monitoring. Each monitored memory word carries a small state code kept elsewhere. For every memory event, the surrounding logic presents the word's current state and an event code. The block looks the pair up in a programmable transition table. It returns the state the word moves to, a flag that says whether the event is illegal in that state, and a flag that says whether the stored state must be rewritten.

Loads, stores and software-issued marker events (allocate, free and so on) are all plain event codes to the block. None of them carries a fixed meaning, so a marker event only changes the state and never touches data. Because every table entry can be written, one instance can host different checkers: heap-use tracking, return-address protection, heap chunk delimiting, or a mix of them.

After reset the table is transparent: every pair keeps its state and raises no exception. The table is loaded one entry per cycle through a configuration port. The event side accepts one event per cycle through a valid/ready handshake and answers one cycle later.

Top module: `mem_state_checker`

## Requirements
- R1: An event accepted on a rising edge (ev_valid and ev_ready both high) produces rsp_valid high on the next edge, with rsp_state equal to the next-state field of the entry at index {ev_state, ev_code}, state in the upper bits.
- R2: With default parameters the table holds 16 states (4-bit state code) by 8 event codes, and each of the 128 entries is programmed and read independently of all the others.
- R3: A configuration write (cfg_we high) stores {cfg_next, cfg_exc} at entry cfg_addr = {state, event} on that edge. Any event accepted on a later edge sees the new entry.
- R4: While cfg_we is high, ev_ready is low, no event is accepted, and rsp_valid is low on the following cycle.
- R5: rsp_exc equals the exception bit of the looked-up entry and is high only in a cycle where rsp_valid is high. When an exception is flagged, rsp_state still carries the entry's next state.
- R6: rsp_wb is high exactly when rsp_valid is high and rsp_state differs from the ev_state of the accepted event.
- R7: After reset every entry maps each state to itself with no exception, so every event returns its own state with rsp_exc and rsp_wb low. Reset also clears rsp_valid.
- R8: When no event is accepted, rsp_valid, rsp_exc and rsp_wb are low on the next cycle. Events on back-to-back cycles each give their own response.
- R9: A heap program runs correctly when encoded as state codes 0 non-heap, 1 unallocated, 2 allocated-uninitialized and 3 initialized, and event codes 0 load, 1 store, 2 allocate and 3 free. Under it: allocate moves 1 to 2, store moves 2 to 3, and free moves 2 or 3 to 1. Load, store or free on 1, load on 2, allocate on 2 or 3, and allocate or free on 0 each raise an exception and keep the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | 7 | Entry index {state, event} |
| cfg_next | input | 4 | Next-state value to store |
| cfg_exc | input | 1 | Exception bit to store |
| ev_valid | input | 1 | Event present |
| ev_ready | output | 1 | Event can be accepted this cycle |
| ev_state | input | 4 | Current state of the word |
| ev_code | input | 3 | Event code |
| rsp_valid | output | 1 | Response present |
| rsp_state | output | 4 | State the word moves to |
| rsp_exc | output | 1 | Event is illegal in the current state |
| rsp_wb | output | 1 | State changed and must be written back |

## Verification
The bench builds the block with its default parameters: 4 state bits and 3 event bits, 128 entries in all. At this size it can sweep every (state, event) pair, first in the reset state and then after loading an arithmetic pattern. The expected next state and exception bit come from a formula in the bench, so every entry, every rewrite decision and every exception position is covered. A second reset and a full heap-checker program then test real lifecycles, including writes that collide with events.

// File: rtl/msc_pkg.sv
package msc_pkg;
   localparam int unsigned MSC_STATE_W_DEF = 4;
   localparam int unsigned MSC_EVENT_W_DEF = 3;

   // state carried in the upper bits of an entry index
   function automatic int unsigned idx_state(input int unsigned idx, input int unsigned ev_w);
      return idx >> ev_w;
   endfunction
endpackage

// File: rtl/msc_table.sv
module msc_table #(
   parameter int unsigned STATE_W = msc_pkg::MSC_STATE_W_DEF,
   parameter int unsigned EVENT_W = msc_pkg::MSC_EVENT_W_DEF,
   localparam int unsigned ADDR_W  = STATE_W + EVENT_W,
   localparam int unsigned DEPTH   = 1 << ADDR_W,
   localparam int unsigned ENTRY_W = STATE_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [ENTRY_W-1:0] wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [ENTRY_W-1:0] rd_data
);
   logic [ENTRY_W-1:0] cells [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_cell
      localparam logic [STATE_W-1:0] SELF =
         STATE_W'(msc_pkg::idx_state(gi, EVENT_W));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cells[gi] <= {SELF, 1'b0};
         else if (wr_en && (wr_addr == ADDR_W'(gi)))
            cells[gi] <= wr_data;
      end
   end

   assign rd_data = cells[rd_addr];

   assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cells[$past(wr_addr)] == $past(wr_data));
endmodule

// File: rtl/msc_resp.sv
module msc_resp #(
   parameter int unsigned STATE_W = msc_pkg::MSC_STATE_W_DEF
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               accept,
   input  logic [STATE_W-1:0] cur_state,
   input  logic [STATE_W-1:0] nxt_state,
   input  logic               nxt_exc,
   output logic               rsp_valid,
   output logic [STATE_W-1:0] rsp_state,
   output logic               rsp_exc,
   output logic               rsp_wb
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_state <= '0;
         rsp_exc   <= 1'b0;
         rsp_wb    <= 1'b0;
      end else if (accept) begin
         rsp_valid <= 1'b1;
         rsp_state <= nxt_state;
         rsp_exc   <= nxt_exc;
         rsp_wb    <= (nxt_state != cur_state);
      end else begin
         rsp_valid <= 1'b0;
         rsp_exc   <= 1'b0;
         rsp_wb    <= 1'b0;
      end
   end

   assert_exc_needs_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_exc |-> rsp_valid);
   assert_wb_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (rsp_wb == (rsp_state != $past(cur_state))));
endmodule

// File: rtl/mem_state_checker.sv
module mem_state_checker #(
   parameter int unsigned STATE_W = msc_pkg::MSC_STATE_W_DEF,
   parameter int unsigned EVENT_W = msc_pkg::MSC_EVENT_W_DEF,
   localparam int unsigned ADDR_W  = STATE_W + EVENT_W,
   localparam int unsigned ENTRY_W = STATE_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_we,
   input  logic [ADDR_W-1:0]  cfg_addr,
   input  logic [STATE_W-1:0] cfg_next,
   input  logic               cfg_exc,
   input  logic               ev_valid,
   output logic               ev_ready,
   input  logic [STATE_W-1:0] ev_state,
   input  logic [EVENT_W-1:0] ev_code,
   output logic               rsp_valid,
   output logic [STATE_W-1:0] rsp_state,
   output logic               rsp_exc,
   output logic               rsp_wb
);
   if (STATE_W < 1 || STATE_W > 6) begin : g_bad_state_w
      $error("mem_state_checker: STATE_W out of range");
   end
   if (EVENT_W < 1 || EVENT_W > 5) begin : g_bad_event_w
      $error("mem_state_checker: EVENT_W out of range");
   end

   logic [ENTRY_W-1:0] entry;
   logic               accept;

   // configuration owns the cycle it writes in
   assign ev_ready = ~cfg_we;
   assign accept   = ev_valid & ev_ready;

   msc_table #(.STATE_W(STATE_W), .EVENT_W(EVENT_W)) u_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_we),
      .wr_addr (cfg_addr),
      .wr_data ({cfg_next, cfg_exc}),
      .rd_addr ({ev_state, ev_code}),
      .rd_data (entry)
   );

   msc_resp #(.STATE_W(STATE_W)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .cur_state (ev_state),
      .nxt_state (entry[ENTRY_W-1:1]),
      .nxt_exc   (entry[0]),
      .rsp_valid (rsp_valid),
      .rsp_state (rsp_state),
      .rsp_exc   (rsp_exc),
      .rsp_wb    (rsp_wb)
   );

   assert_accept_answers_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_ready) |=> rsp_valid);
   assert_cfg_blocks_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> !rsp_valid);
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_valid && ev_ready) |=> !(rsp_valid || rsp_exc || rsp_wb));
endmodule

// File: tb/tb_mem_state_checker.sv
module tb_mem_state_checker;
   localparam int CLK_PERIOD = 10;

   logic       clk = 0;
   logic       rst_n = 0;
   logic       cfg_we = 0;
   logic [6:0] cfg_addr = '0;
   logic [3:0] cfg_next = '0;
   logic       cfg_exc = 0;
   logic       ev_valid = 0;
   logic       ev_ready;
   logic [3:0] ev_state = '0;
   logic [2:0] ev_code = '0;
   logic       rsp_valid;
   logic [3:0] rsp_state;
   logic       rsp_exc;
   logic       rsp_wb;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mem_state_checker dut (.*);

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int pat_next(input int s, input int e);
      return (s * 3 + e + 1) % 16;
   endfunction
   function automatic int pat_exc(input int s, input int e);
      return ((s + e) % 3 == 0) ? 1 : 0;
   endfunction

   // heap program: states 0 nonheap,1 unalloc,2 uninit,3 init; events 0 ld,1 st,2 alloc,3 free
   function automatic int heap_next(input int s, input int e);
      if (s == 1 && e == 2) return 2;
      if (s == 2 && e == 1) return 3;
      if ((s == 2 || s == 3) && e == 3) return 1;
      return s;
   endfunction
   function automatic int heap_exc(input int s, input int e);
      if (s == 1 && e != 2) return 1;
      if (s == 2 && e == 0) return 1;
      if ((s == 2 || s == 3) && e == 2) return 1;
      if (s == 0 && (e == 2 || e == 3)) return 1;
      return 0;
   endfunction

   task automatic cfg_write(input int a, input int n, input int x);
      @(negedge clk);
      cfg_we = 1; cfg_addr = 7'(a); cfg_next = 4'(n); cfg_exc = x[0];
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic event_check(input string req, input int s, input int e,
                              input int en, input int ex);
      @(negedge clk);
      ev_valid = 1; ev_state = 4'(s); ev_code = 3'(e);
      @(negedge clk);
      ev_valid = 0;
      chk(req, rsp_valid, 1);
      chk(req, rsp_state, en);
      chk(req, rsp_exc, ex);
      chk(req, rsp_wb, (en != s) ? 1 : 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R7: reset state of outputs
      chk("R7", rsp_valid, 0);
      chk("R7", ev_ready, 1);
      rst_n = 1;
      // R7: transparent table over all pairs
      for (int s = 0; s < 16; s++)
         for (int e = 0; e < 8; e++)
            event_check("R7", s, e, s, 0);
      // R8: idle cycle gives nothing
      @(negedge clk);
      chk("R8", rsp_valid, 0);
      chk("R8", rsp_wb, 0);
      // R2/R3: program every entry with a pattern
      for (int a = 0; a < 128; a++)
         cfg_write(a, pat_next(a >> 3, a & 7), pat_exc(a >> 3, a & 7));
      // R1/R2/R5/R6: sweep all pairs
      for (int s = 0; s < 16; s++)
         for (int e = 0; e < 8; e++)
            event_check("R1", s, e, pat_next(s, e), pat_exc(s, e));
      // R8: back-to-back events
      @(negedge clk);
      ev_valid = 1; ev_state = 4'd5; ev_code = 3'd2;
      @(negedge clk);
      chk("R8", rsp_state, pat_next(5, 2));
      ev_state = 4'd9; ev_code = 3'd6;
      @(negedge clk);
      ev_valid = 0;
      chk("R8", rsp_valid, 1);
      chk("R8", rsp_state, pat_next(9, 6));
      chk("R5", rsp_exc, pat_exc(9, 6));
      @(negedge clk);
      chk("R8", rsp_exc, 0);
      // R4: write collides with an event
      @(negedge clk);
      cfg_we = 1; cfg_addr = {4'd4, 3'd4}; cfg_next = 4'd4; cfg_exc = 1;
      ev_valid = 1; ev_state = 4'd7; ev_code = 3'd1;
      #1 chk("R4", ev_ready, 0);
      @(negedge clk);
      cfg_we = 0; ev_valid = 0;
      chk("R4", rsp_valid, 0);
      // R3: new entry visible, same state so no rewrite, exception still reported (R5)
      event_check("R3", 4, 4, 4, 1);
      // R7: reset again restores transparency
      @(negedge clk);
      rst_n = 0;
      @(negedge clk);
      chk("R7", rsp_valid, 0);
      rst_n = 1;
      event_check("R7", 4, 4, 4, 0);
      event_check("R7", 9, 6, 9, 0);
      // R9: heap checker program
      for (int a = 0; a < 128; a++)
         cfg_write(a, heap_next(a >> 3, a & 7), heap_exc(a >> 3, a & 7));
      for (int s = 0; s < 4; s++)
         for (int e = 0; e < 4; e++)
            event_check("R9", s, e, heap_next(s, e), heap_exc(s, e));
      // R9: a lifecycle unalloc -> alloc -> store -> load -> free
      event_check("R9", 1, 2, 2, 0);
      event_check("R9", 2, 1, 3, 0);
      event_check("R9", 3, 0, 3, 0);
      event_check("R9", 3, 3, 1, 0);
      event_check("R9", 1, 0, 1, 1);
      done = 1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=done", cyc);
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule